// File: doc/BRIEF.md
# Processor Identification Range Matcher

This block decides whether a 32-bit processor identification word falls inside any entry of a small table of model and version ranges. Each table entry holds a model value, a lower version bound and an upper version bound. The table is loaded through a plain write port. A one-cycle start pulse then launches a sequential scan that reads one entry per clock.

The model of the identification word keeps only the implementor, architecture and part-number fields. The version keeps only the variant and revision fields, which stay in their own bit positions. The scan stops at the first entry whose model equals the word's model and whose bounds enclose the version. It also stops at an entry whose model is zero, which ends the list, or after the last table slot.

When the scan ends, the block raises `done` for one cycle. `match` and `match_idx` then hold the result until the next accepted start. The identification word is captured when the start pulse is accepted, so the input may change during a scan.

Top module: `id_range_matcher`

## Requirements
- R1: The model comparison uses only bits 31:24 (implementor), 19:16 (architecture) and 15:4 (part number) of the identification word. Bits 23:20 and 3:0 have no effect on the model test.
- R2: The version is the identification word with only bits 23:20 (variant) and 3:0 (revision) kept, unshifted. It is compared unsigned, so every revision of variant v sorts below revision 0 of variant v+1.
- R3: A version bound is inclusive at both ends. A version equal to the lower bound matches, and so does a version equal to the upper bound. A version one step outside either bound does not match.
- R4: Entries are examined from index 0 upward. The scan ends with `match`=1 and `match_idx` equal to the index of the first matching entry.
- R5: An entry whose model is zero ends the scan with `match`=0, and that entry is never compared. A table cleared by reset therefore never matches.
- R6: If no entry matches and no zero-model entry is present, the scan ends after index DEPTH-1 with `match`=0.
- R7: `done` is high for exactly one cycle. If the scan ends at index k, `done` rises k+1 cycles after the clock edge that accepted `start`. `busy` is high from that edge until the edge that raises `done`.
- R8: An accepted start clears `match` and `match_idx`. From `done` until the next accepted start, both outputs stay stable.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running scan keeps its timing and result.
- R10: After synchronous reset, `busy`, `done`, `match` and `match_idx` are zero, and every table entry is zero.
- R11: When `wr_en` is high at a clock edge, the entry at `wr_idx` takes `wr_model`, `wr_vmin` and `wr_vmax`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_model | input | 32 | Model value for the entry (zero marks end of list) |
| wr_vmin | input | 32 | Lower version bound, variant/revision in place |
| wr_vmax | input | 32 | Upper version bound, variant/revision in place |
| id_word | input | 32 | Identification word to classify |
| start | input | 1 | One-cycle pulse that begins a scan |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |
| match | output | 1 | Last scan found a matching entry |
| match_idx | output | IDX_W | Index of the matching entry |

## Verification
Some rules are checked by assertions on every cycle:
- `done` is a single-cycle pulse and never overlaps `busy`.
- The entry pointer advances by one for each entry that neither matches nor ends the list.
- A zero-model entry always ends the scan without a match.
- A hit always ends the scan with the current index.
- The result registers do not move while the block is idle.
- A table write lands in the addressed entry.

Other behaviour only the bench's scenarios can show, using expected values it computes itself:
- that model masking ignores only the variant and revision bits;
- that the version packing orders variant above revision;
- that both bounds are inclusive;
- the exact latency to `done`;
- that a start pulse is ignored in the middle of a scan.

// File: rtl/idm_pkg.sv
package idm_pkg;

    localparam logic [31:0] MODEL_MASK = 32'hFF0F_FFF0;
    localparam logic [31:0] VER_MASK   = 32'h00F0_000F;

    typedef struct packed {
        logic [31:0] model;
        logic [31:0] vmin;
        logic [31:0] vmax;
    } range_entry_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    function automatic logic [31:0] model_of(input logic [31:0] word);
        return word & MODEL_MASK;
    endfunction

    function automatic logic [31:0] version_of(input logic [31:0] word);
        return word & VER_MASK;
    endfunction

    function automatic logic [31:0] make_model(input logic [7:0] imp, input logic [11:0] part);
        return {imp, 4'h0, 4'hF, part, 4'h0};
    endfunction

    function automatic logic [31:0] make_ver(input logic [3:0] variant, input logic [3:0] rev);
        return {8'h00, variant, 16'h0000, rev};
    endfunction

endpackage

// File: rtl/idm_table.sv
module idm_table
    import idm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  range_entry_t       wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output range_entry_t       rd_data
);

    range_entry_t mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                mem[g] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_data))) // R11
        else $error("table write lost");

endmodule

// File: rtl/idm_compare.sv
module idm_compare
    import idm_pkg::*;
(
    input  logic [31:0]  word,
    input  range_entry_t entry,
    output logic         is_end,
    output logic         hit
);

    logic [31:0] ver;
    logic        model_eq;
    logic        in_range;

    always_comb begin
        ver      = version_of(word);
        is_end   = (entry.model == 32'h0);
        model_eq = (model_of(word) == entry.model);
        in_range = (ver >= entry.vmin) && (ver <= entry.vmax);
        hit      = !is_end && model_eq && in_range;
    end

endmodule

// File: rtl/idm_scan_ctrl.sv
module idm_scan_ctrl
    import idm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      id_word,
    input  logic             is_end,
    input  logic             hit,
    output logic [IDX_W-1:0] ptr,
    output logic [31:0]      scan_word,
    output logic             busy,
    output logic             done,
    output logic             match,
    output logic [IDX_W-1:0] match_idx
);

    scan_state_e state;

    assign busy = (state == ST_SCAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ptr       <= '0;
            scan_word <= '0;
            done      <= 1'b0;
            match     <= 1'b0;
            match_idx <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_SCAN;
                        ptr       <= '0;
                        scan_word <= id_word;
                        match     <= 1'b0;
                        match_idx <= '0;
                    end
                end
                ST_SCAN: begin
                    if (is_end) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else if (hit) begin
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                        match     <= 1'b1;
                        match_idx <= ptr;
                    end else if (ptr == LAST) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        ptr <= ptr + IDX_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) // R7
        else $error("done longer than one cycle");

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) // R7
        else $error("done while busy");

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (busy && !is_end && !hit && (ptr != LAST)) |=> (busy && (ptr == $past(ptr) + IDX_W'(1)))) // R4
        else $error("pointer did not advance");

    AST_END_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
        (busy && is_end) |=> (done && !match)) // R5
        else $error("end marker did not stop scan");

    AST_HIT_REPORTS: assert property (@(posedge clk) disable iff (rst)
        (busy && hit) |=> (done && match && (match_idx == $past(ptr)))) // R4
        else $error("hit not reported");

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(match) && $stable(match_idx))) // R8
        else $error("result moved while idle");

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !is_end && !hit && (ptr != LAST)) |=> (ptr != '0)) // R9
        else $error("start restarted scan");

endmodule

// File: rtl/id_range_matcher.sv
module id_range_matcher
    import idm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_model,
    input  logic [31:0]      wr_vmin,
    input  logic [31:0]      wr_vmax,
    input  logic [31:0]      id_word,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             match,
    output logic [IDX_W-1:0] match_idx
);

    range_entry_t     wr_data;
    range_entry_t     cur_entry;
    logic [IDX_W-1:0] ptr;
    logic [31:0]      scan_word;
    logic             is_end;
    logic             hit;

    assign wr_data = '{model: wr_model, vmin: wr_vmin, vmax: wr_vmax};

    idm_table #(.DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (ptr),
        .rd_data (cur_entry)
    );

    idm_compare u_cmp (
        .word   (scan_word),
        .entry  (cur_entry),
        .is_end (is_end),
        .hit    (hit)
    );

    idm_scan_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .id_word   (id_word),
        .is_end    (is_end),
        .hit       (hit),
        .ptr       (ptr),
        .scan_word (scan_word),
        .busy      (busy),
        .done      (done),
        .match     (match),
        .match_idx (match_idx)
    );

endmodule

// File: tb/id_range_matcher_bench.sv
module id_range_matcher_bench;
    import idm_pkg::*;

    localparam int DEPTH = 8;
    localparam int IDX_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [31:0]      wr_model = '0, wr_vmin = '0, wr_vmax = '0;
    logic [31:0]      id_word = '0;
    logic             start = 1'b0;
    logic             busy, done, match;
    logic [IDX_W-1:0] match_idx;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    logic [31:0] t_model [DEPTH];
    logic [31:0] t_vmin  [DEPTH];
    logic [31:0] t_vmax  [DEPTH];

    always #2 clk = ~clk;

    id_range_matcher #(.DEPTH(DEPTH)) u_id_range_matcher (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_model(wr_model), .wr_vmin(wr_vmin), .wr_vmax(wr_vmax),
        .id_word(id_word), .start(start), .busy(busy), .done(done),
        .match(match), .match_idx(match_idx)
    );

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_entry(input int i, input logic [31:0] m, input logic [31:0] lo, input logic [31:0] hi);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(i); wr_model = m; wr_vmin = lo; wr_vmax = hi;
        t_model[i] = m; t_vmin[i] = lo; t_vmax[i] = hi;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic void expect_scan(input logic [31:0] w, output bit m, output int idx, output int stop);
        logic [31:0] ver;
        ver = w & 32'h00F0_000F;
        m = 0; idx = 0; stop = DEPTH - 1;
        for (int i = 0; i < DEPTH; i++) begin
            if (t_model[i] == 32'h0) begin
                stop = i;
                return;
            end
            if (((w & 32'hFF0F_FFF0) == t_model[i]) && ver >= t_vmin[i] && ver <= t_vmax[i]) begin
                m = 1; idx = i; stop = i;
                return;
            end
        end
    endfunction

    // Runs a scan; restart_at > 0 pulses start again that many cycles into the scan.
    task automatic run_scan(input string req, input logic [31:0] w, input int restart_at);
        bit em; int ei, es; int n;
        expect_scan(w, em, ei, es);
        @(negedge clk);
        id_word = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        id_word = ~w;
        n = 0;
        while (n < 40) begin
            @(negedge clk);
            n++;
            start = (restart_at > 0 && n == restart_at) ? 1'b1 : 1'b0;
            if (done) break;
        end
        start = 1'b0;
        check({req, " latency R7"}, n, es + 1);
        check({req, " match"}, {31'b0, match}, {31'b0, em});
        if (em) check({req, " index R4"}, {{(32-IDX_W){1'b0}}, match_idx}, ei);
    endtask

    logic [31:0] m_a, m_b, w;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            t_model[i] = '0; t_vmin[i] = '0; t_vmax[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 busy", {31'b0, busy}, 0);
        check("R10 done", {31'b0, done}, 0);
        check("R10 match", {31'b0, match}, 0);
        check("R10 idx", {29'b0, match_idx}, 0);
        // R5/R10: empty table stops at entry 0
        run_scan("R5 empty table", make_model(8'h41, 12'hD03), 0);

        m_a = make_model(8'h41, 12'hD03);
        m_b = make_model(8'h43, 12'h0A1);
        write_entry(0, m_b, make_ver(4'h1, 4'h2), make_ver(4'h2, 4'h0));      // R11
        write_entry(1, m_a, make_ver(4'h0, 4'h0), make_ver(4'hF, 4'hF));
        // R1: variant/revision ignored for model; architecture not
        run_scan("R1 any version", m_a | make_ver(4'h3, 4'h5), 0);
        run_scan("R1 arch differs", (m_a & ~32'h000F_0000) | 32'h000E_0000, 0);
        // R3 bounds inclusive, R2 packing
        run_scan("R3 low bound", m_b | make_ver(4'h1, 4'h2), 0);
        run_scan("R3 below low", m_b | make_ver(4'h1, 4'h1), 0);
        run_scan("R3 high bound", m_b | make_ver(4'h2, 4'h0), 0);
        run_scan("R3 above high", m_b | make_ver(4'h2, 4'h1), 0);
        run_scan("R2 variant over revision", m_b | make_ver(4'h1, 4'hF), 0);
        run_scan("R2 revision of low variant", m_b | make_ver(4'h0, 4'hF), 0);
        // R4 first match wins
        write_entry(2, m_a, make_ver(4'h0, 4'h0), make_ver(4'h0, 4'h3));
        run_scan("R4 first of two", m_a | make_ver(4'h0, 4'h1), 0);
        // R8 hold after done
        repeat (3) @(negedge clk);
        check("R8 match held", {31'b0, match}, 1);
        check("R8 idx held", {29'b0, match_idx}, 1);
        // R5: sentinel hides later entries
        write_entry(4, m_b, make_ver(4'h0, 4'h0), make_ver(4'hF, 4'hF));
        run_scan("R5 behind sentinel", m_b | make_ver(4'h5, 4'h0), 0);
        // R6/R9: full table with no sentinel
        for (int i = 0; i < DEPTH; i++)
            write_entry(i, make_model(8'h50, 12'(i + 1)), make_ver(4'h0, 4'h0), make_ver(4'hF, 4'hF));
        run_scan("R6 full miss", m_a, 0);
        run_scan("R9 restart ignored", m_a, 3);
        run_scan("R4 last slot", make_model(8'h50, 12'(DEPTH)) | make_ver(4'h7, 4'h7), 0);
        run_scan("R9 restart during hit scan", make_model(8'h50, 12'(DEPTH)), 2);

        // Constrained random
        void'($urandom(32'd2024));
        for (int r = 0; r < 150; r++) begin
            if (r % 10 == 0) begin
                for (int i = 0; i < DEPTH; i++) begin
                    logic [3:0] v0, v1, r0, r1;
                    v0 = 4'($urandom_range(0, 15)); v1 = 4'($urandom_range(0, 15));
                    r0 = 4'($urandom_range(0, 15)); r1 = 4'($urandom_range(0, 15));
                    if ({v0, r0} > {v1, r1}) begin
                        write_entry(i, ($urandom_range(0, 9) == 0) ? 32'h0 :
                                    make_model(8'h41, 12'(12'hD00 + $urandom_range(0, 3))),
                                    make_ver(v1, r1), make_ver(v0, r0));
                    end else begin
                        write_entry(i, ($urandom_range(0, 9) == 0) ? 32'h0 :
                                    make_model(8'h41, 12'(12'hD00 + $urandom_range(0, 3))),
                                    make_ver(v0, r0), make_ver(v1, r1));
                    end
                end
            end
            w = make_model(8'h41, 12'(12'hD00 + $urandom_range(0, 3))) |
                make_ver(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
            run_scan("R4 random", w, 0);
        end
        summary();
    end

endmodule